// File: doc/BRIEF.md
# Interrupt Claim and Notification Engine

This block tracks a pending bit and a claimed bit for every interrupt source and works out, for each of several contexts, whether a source is waiting that the context should service. The source lines are level driven. Per-source priorities, per-context enable masks, per-context thresholds and per-context privilege modes are set outside the block and arrive as plain inputs. For each context the block raises a notification and routes it to a machine-level or a supervisor-level external interrupt line according to that context's mode.

A context takes a source with a claim request. The block picks the lowest-numbered source eligible for that context, marks it claimed and reports its ID one clock later. Once serviced, the context returns the source with a complete request carrying the ID. A claimed source is invisible to every context until completed. When several contexts claim in the same cycle, they are served in context order within that cycle, so no source goes to two contexts.

Each context has a response state machine with three states. RSP_IDLE: no response this cycle. RSP_HIT: a source was granted and its ID is on the output. RSP_MISS: a claim found nothing, and the ID output reads 0. A claim request with an eligible source moves any state to RSP_HIT (transition "grant"). A claim request with nothing eligible moves any state to RSP_MISS (transition "empty"). With no request, any state moves to RSP_IDLE (transition "drop"). RSP_HIT and RSP_MISS therefore last one cycle unless another claim follows at once.

Top module: `irq_claim_engine`

## Requirements
- R1: After reset every pending and claimed bit is clear, so every notify, meip, seip and claim_ack output is 0.
- R2: On each rising clock edge the pending bit of source n takes the level on src_level[n]. Source 0 is reserved and its pending bit is never set.
- R3: Source n is eligible for context c when it is pending, not claimed, has enable bit ctx_enable[c*NWORDS*32 + n] set (word n>>5, bit n&31 of that context's enable words) and has a priority src_prio[n*PRIO_W +: PRIO_W] strictly greater than ctx_thresh[c*PRIO_W +: PRIO_W]. A priority equal to the threshold does not qualify.
- R4: notify[c] is 1 exactly when at least one source is eligible for context c. It follows priority, enable and threshold inputs in the same cycle and follows pending and claimed state from the edge that changes it.
- R5: A claim_req[c] sampled at an edge produces claim_ack[c]=1 for the following cycle. If any source was eligible, claim_hit[c]=1 and claim_id[c*IDW +: IDW] holds the lowest-numbered eligible source, regardless of priority.
- R6: A successful claim sets the granted source's claimed bit and clears its pending bit at the same edge. The claimed source is not eligible for any context until completed, even with its input held high.
- R7: A claim that finds no eligible source gives claim_ack=1, claim_hit=0, claim_id=0, and changes no pending or claimed bit.
- R8: complete_req[c] with ID k clears the claimed bit of source k at the edge. The pending bit keeps following the source level alone. An ID of 0 or of NSRC or more changes nothing.
- R9: When several contexts claim in the same cycle, the lowest-numbered context is served first and each later context picks from the sources not granted to earlier ones, so no source is granted twice.
- R10: ctx_mode[c*2 +: 2] selects routing: 3 (machine) drives meip[c]=notify[c], 1 (supervisor) drives seip[c]=notify[c], and 0 or 2 drive neither line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NSRC | Level of each interrupt source |
| src_prio | input | NSRC*PRIO_W | Priority of each source, source n in bits n*PRIO_W upward |
| ctx_enable | input | NCTX*NWORDS*32 | Enable words per context, NWORDS 32-bit words each |
| ctx_thresh | input | NCTX*PRIO_W | Threshold per context |
| ctx_mode | input | NCTX*2 | Privilege mode per context: 0 user, 1 supervisor, 2 hypervisor, 3 machine |
| claim_req | input | NCTX | Claim request per context |
| complete_req | input | NCTX | Complete request per context |
| complete_id | input | NCTX*IDW | Source ID being completed, per context |
| claim_ack | output | NCTX | Claim response valid, one cycle after the request |
| claim_hit | output | NCTX | Claim response found a source |
| claim_id | output | NCTX*IDW | Granted source ID, 0 on a miss or when idle |
| notify | output | NCTX | At least one eligible source per context |
| meip | output | NCTX | Machine external interrupt line per context |
| seip | output | NCTX | Supervisor external interrupt line per context |

## Verification
The notify, meip and seip outputs follow priority, enable, threshold and mode inputs in the same cycle. They follow a source level change one rising edge later, because the pending bit is a register. A claim response is visible one rising edge after the request, and the claimed bit it sets, like the clear from a complete, reaches notify at that same edge. The bench therefore drives every input just after a falling edge and samples on the next falling edge, or a nanosecond after a purely combinational change, so each expected value is read in the cycle it is due and never at an edge.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;

    typedef enum logic [1:0] {
        PRIV_USER    = 2'd0,
        PRIV_SUPER   = 2'd1,
        PRIV_HYPER   = 2'd2,
        PRIV_MACHINE = 2'd3
    } priv_mode_e;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/irq_prio_mask.sv
// Per-context qualification mask: enable bit set and priority above threshold.
module irq_prio_mask #(
    parameter int NSRC   = 40,
    parameter int PRIO_W = 3
) (
    input  logic [NSRC*PRIO_W-1:0] src_prio,
    input  logic [PRIO_W-1:0]      thresh,
    input  logic [NSRC-1:0]        enable_bits,
    output logic [NSRC-1:0]        mask
);

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        assign mask[n] = enable_bits[n] && (src_prio[n*PRIO_W +: PRIO_W] > thresh);
    end

endmodule

// File: rtl/irq_first_pick.sv
// Lowest-index selector over a candidate vector.
module irq_first_pick #(
    parameter int N   = 40,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   cand,
    output logic           found,
    output logic [N-1:0]   onehot,
    output logic [IDW-1:0] id
);

    always_comb begin
        id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                id = IDW'(i);
            end
        end
    end

    assign onehot = cand & (~cand + N'(1));
    assign found  = |cand;

endmodule

// File: rtl/irq_claim_port.sv
// Response state machine for one context's claim requests.
module irq_claim_port
    import irq_claim_pkg::*;
#(
    parameter int IDW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           found,
    input  logic [IDW-1:0] pick_id,
    output logic           ack,
    output logic           hit,
    output logic [IDW-1:0] id
);

    rsp_state_e     state_q, state_d;
    logic [IDW-1:0] id_q;

    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_HIT, RSP_MISS: begin
                if (req && found) begin
                    state_d = RSP_HIT;
                end else if (req) begin
                    state_d = RSP_MISS;
                end else begin
                    state_d = RSP_IDLE;
                end
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (req && found) begin
                id_q <= pick_id;
            end
        end
    end

    always_comb begin
        ack = 1'b0;
        hit = 1'b0;
        id  = '0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT: begin
                ack = 1'b1;
                hit = 1'b1;
                id  = id_q;
            end
            RSP_MISS: ack = 1'b1;
            default: ;
        endcase
    end

    // R5: a response appears only in the cycle after a request
    p_ack_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));

    // R5: a granted ID is never the reserved source 0
    p_hit_id_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (id != '0));

    // R7: a miss reports ID 0
    p_miss_id_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |-> (id == '0));

endmodule

// File: rtl/irq_claim_engine.sv
module irq_claim_engine
    import irq_claim_pkg::*;
#(
    parameter int NSRC   = 40,
    parameter int NCTX   = 3,
    parameter int PRIO_W = 3,
    localparam int NWORDS = (NSRC + 31) / 32,
    localparam int EW     = NWORDS * 32,
    localparam int IDW    = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        src_level,
    input  logic [NSRC*PRIO_W-1:0] src_prio,
    input  logic [NCTX*EW-1:0]     ctx_enable,
    input  logic [NCTX*PRIO_W-1:0] ctx_thresh,
    input  logic [NCTX*2-1:0]      ctx_mode,
    input  logic [NCTX-1:0]        claim_req,
    input  logic [NCTX-1:0]        complete_req,
    input  logic [NCTX*IDW-1:0]    complete_id,
    output logic [NCTX-1:0]        claim_ack,
    output logic [NCTX-1:0]        claim_hit,
    output logic [NCTX*IDW-1:0]    claim_id,
    output logic [NCTX-1:0]        notify,
    output logic [NCTX-1:0]        meip,
    output logic [NCTX-1:0]        seip
);

    localparam logic [NSRC-1:0] SRC0_OFF = ~NSRC'(1);

    logic [NSRC-1:0] pend_q, claimed_q, base;
    logic [NSRC-1:0] qual     [NCTX];
    logic [NSRC-1:0] avail    [NCTX];
    logic [NSRC-1:0] cand     [NCTX];
    logic [NSRC-1:0] pick_oh  [NCTX];
    logic [NSRC-1:0] grant    [NCTX];
    logic [NSRC-1:0] done_msk [NCTX];
    logic [IDW-1:0]  pick_id  [NCTX];
    logic [NCTX-1:0] found;
    logic [NSRC-1:0] grant_all, done_all;

    assign base     = pend_q & ~claimed_q;
    assign avail[0] = base;

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        logic [IDW-1:0] cid;
        priv_mode_e     mode;

        irq_prio_mask #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_mask (
            .src_prio    (src_prio),
            .thresh      (ctx_thresh[c*PRIO_W +: PRIO_W]),
            .enable_bits (ctx_enable[c*EW +: NSRC]),
            .mask        (qual[c])
        );

        assign notify[c] = |(base & qual[c]);
        assign cand[c]   = avail[c] & qual[c];

        irq_first_pick #(.N(NSRC), .IDW(IDW)) u_pick (
            .cand   (cand[c]),
            .found  (found[c]),
            .onehot (pick_oh[c]),
            .id     (pick_id[c])
        );

        assign grant[c] = claim_req[c] ? pick_oh[c] : '0;

        if (c + 1 < NCTX) begin : g_chain
            assign avail[c+1] = avail[c] & ~grant[c];
        end

        assign cid = complete_id[c*IDW +: IDW];
        assign done_msk[c] = (complete_req[c] && (cid != '0) && (int'(cid) < NSRC))
                             ? (NSRC'(1) << cid) : '0;

        assign mode    = priv_mode_e'(ctx_mode[c*2 +: 2]);
        assign meip[c] = notify[c] && (mode == PRIV_MACHINE);
        assign seip[c] = notify[c] && (mode == PRIV_SUPER);

        irq_claim_port #(.IDW(IDW)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (claim_req[c]),
            .found   (found[c]),
            .pick_id (pick_id[c]),
            .ack     (claim_ack[c]),
            .hit     (claim_hit[c]),
            .id      (claim_id[c*IDW +: IDW])
        );

        // R5: at most one source granted per context per cycle
        p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[c]));

        if (c > 0) begin : g_disjoint
            // R9: neighbouring contexts never receive the same source
            p_grants_disjoint_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[c] & grant[c-1]) == '0);
        end

        // R10: a context never drives both external interrupt lines
        p_route_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(meip[c] && seip[c]));
    end

    always_comb begin
        grant_all = '0;
        done_all  = '0;
        for (int c = 0; c < NCTX; c++) begin
            grant_all = grant_all | grant[c];
            done_all  = done_all | done_msk[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= '0;
            claimed_q <= '0;
        end else begin
            pend_q    <= src_level & ~grant_all & SRC0_OFF;
            claimed_q <= (claimed_q & ~done_all) | grant_all;
        end
    end

    // R6: every granted source is marked claimed at the next cycle
    p_claimed_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_all != '0) |=> ((claimed_q & $past(grant_all)) == $past(grant_all)));

    // R4: a claim by context 0 while it is notified always finds a source
    p_notify_found_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_req[0] && notify[0]) |-> found[0]);

    // R2: the reserved source never becomes pending
    p_src0_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]);

endmodule

// File: tb/sim_irq_claim_engine.sv
`timescale 1ns/1ps
module sim_irq_claim_engine;

    localparam int NSRC   = 40;
    localparam int NCTX   = 3;
    localparam int PRIO_W = 3;
    localparam int EW     = 64;
    localparam int IDW    = 6;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NSRC-1:0]        src_level = '0;
    logic [NSRC*PRIO_W-1:0] src_prio = '0;
    logic [NCTX*EW-1:0]     ctx_enable = '0;
    logic [NCTX*PRIO_W-1:0] ctx_thresh = '0;
    logic [NCTX*2-1:0]      ctx_mode = '0;
    logic [NCTX-1:0]        claim_req = '0;
    logic [NCTX-1:0]        complete_req = '0;
    logic [NCTX*IDW-1:0]    complete_id = '0;
    logic [NCTX-1:0]        claim_ack, claim_hit, notify, meip, seip;
    logic [NCTX*IDW-1:0]    claim_id;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_claim_engine #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .src_prio(src_prio),
        .ctx_enable(ctx_enable), .ctx_thresh(ctx_thresh), .ctx_mode(ctx_mode),
        .claim_req(claim_req), .complete_req(complete_req), .complete_id(complete_id),
        .claim_ack(claim_ack), .claim_hit(claim_hit), .claim_id(claim_id),
        .notify(notify), .meip(meip), .seip(seip)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_prio(input int n, input int p);
        src_prio[n*PRIO_W +: PRIO_W] = PRIO_W'(p);
    endtask

    task automatic set_en(input int c, input int n, input logic v);
        ctx_enable[c*EW + (n >> 5)*32 + (n & 31)] = v;
    endtask

    task automatic set_thr(input int c, input int t);
        ctx_thresh[c*PRIO_W +: PRIO_W] = PRIO_W'(t);
    endtask

    task automatic claim(input int c, input int exp_hit, input int exp_id, input string tag);
        claim_req[c] = 1'b1;
        tick();
        claim_req[c] = 1'b0;
        check({tag, " ack"}, int'(claim_ack[c]), 1);
        check({tag, " hit"}, int'(claim_hit[c]), exp_hit);
        check({tag, " id"}, int'(claim_id[c*IDW +: IDW]), exp_id);
    endtask

    task automatic complete(input int c, input int id);
        complete_req[c] = 1'b1;
        complete_id[c*IDW +: IDW] = IDW'(id);
        tick();
        complete_req[c] = 1'b0;
    endtask

    task automatic clear_all();
        src_level  = '0;
        ctx_enable = '0;
        ctx_thresh = '0;
        tick();
        tick();
    endtask

    task automatic t_reset();
        check("R1 notify", int'(notify), 0);
        check("R1 ack", int'(claim_ack), 0);
        check("R1 meip", int'(meip), 0);
        check("R1 seip", int'(seip), 0);
    endtask

    task automatic t_notify_route();
        ctx_mode = {2'd0, 2'd1, 2'd3};
        set_prio(5, 2);
        set_thr(0, 1);
        set_en(0, 5, 1'b1);
        src_level[5] = 1'b1;
        #1 check("R2 level not yet sampled", int'(notify[0]), 0);
        tick();
        check("R4 notify after edge", int'(notify[0]), 1);
        check("R10 machine line", int'(meip[0]), 1);
        check("R10 no supervisor line", int'(seip[0]), 0);
        set_thr(0, 2);
        #1 check("R3 equal threshold", int'(notify[0]), 0);
        set_thr(0, 1);
        set_en(0, 5, 1'b0);
        #1 check("R3 enable off", int'(notify[0]), 0);
        set_en(1, 5, 1'b1);
        set_en(2, 5, 1'b1);
        #1;
        check("R10 supervisor line", int'(seip[1]), 1);
        check("R10 supervisor no meip", int'(meip[1]), 0);
        check("R4 user ctx notify", int'(notify[2]), 1);
        check("R10 user ctx silent", int'(meip[2] | seip[2]), 0);
        src_level[5] = 1'b0;
        tick();
        check("R2 level low clears", int'(notify), 0);
        src_level[0] = 1'b1;
        set_prio(0, 7);
        set_en(2, 0, 1'b1);
        tick();
        check("R2 source 0 reserved", int'(notify[2]), 0);
        clear_all();
    endtask

    task automatic t_lowest_first();
        set_prio(7, 1);
        set_prio(35, 7);
        set_thr(0, 0);
        set_en(0, 7, 1'b1);
        set_en(0, 35, 1'b1);
        src_level[7]  = 1'b1;
        src_level[35] = 1'b1;
        tick();
        claim(0, 1, 7, "R5 lowest id");
        claim(0, 1, 35, "R5 second word");
        check("R6 claimed excluded", int'(notify[0]), 0);
        claim(0, 0, 0, "R7 miss");
        check("R7 miss keeps state", int'(notify[0]), 0);
        complete(0, 7);
        check("R8 complete restores", int'(notify[0]), 1);
        claim(0, 1, 7, "R8 reclaim");
        complete(0, 50);
        complete(0, 0);
        check("R8 bad ids ignored", int'(notify[0]), 0);
        src_level[35] = 1'b0;
        tick();
        complete(0, 35);
        check("R8 pending not set by complete", int'(notify[0]), 0);
        claim(0, 0, 0, "R8 nothing after complete");
        complete(0, 7);
        clear_all();
    endtask

    task automatic t_multi_ctx();
        set_prio(9, 3);
        set_prio(12, 3);
        set_en(0, 9, 1'b1);
        set_en(0, 12, 1'b1);
        set_en(1, 9, 1'b1);
        set_en(1, 12, 1'b1);
        src_level[9]  = 1'b1;
        src_level[12] = 1'b1;
        tick();
        claim_req = 3'b011;
        tick();
        claim_req = '0;
        check("R9 ctx0 first", int'(claim_id[0 +: IDW]), 9);
        check("R9 ctx1 next", int'(claim_id[IDW +: IDW]), 12);
        check("R9 both hit", int'(claim_hit[1:0]), 3);
        claim_req = 3'b011;
        tick();
        claim_req = '0;
        check("R9 both miss", int'(claim_hit[1:0]), 0);
        check("R9 both acked", int'(claim_ack[1:0]), 3);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_notify_route();
        t_lowest_first();
        t_multi_ctx();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule